// File: doc/BRIEF.md
# Floating-Point NaN and Result Fix-Up

This block is a purely combinational stage that follows a single- or double-precision arithmetic datapath. It receives the raw IEEE-754 result of an operation together with the bit patterns of up to three source operands. It corrects the result according to fixed NaN rules and an optional flush-to-zero rule. It returns the corrected value and an invalid-operation indication. The arithmetic, rounding and the other exception flags belong to the datapath in front of it.

When the raw result is a NaN, the block picks a value in this order. Default-NaN mode and operand-free NaNs give the canonical quiet NaN. Otherwise a signalling NaN operand wins over a quiet one, with operand 1 first, then operand 2, then operand 3. A per-operand enable marks which operands the operation really has, so that unary and binary operations can share the stage. Results that are not NaNs are either flushed, when they are subnormal and flush-to-zero is on, or passed through unchanged.

Top module: `fpfix_top`

## Requirements
- R1: When the raw result is a NaN and no enabled operand is a NaN, the output is the canonical quiet NaN: 0x7FC00000 in single precision, 0x7FF8000000000000 in double precision.
- R2: When default-NaN mode is on and the raw result is a NaN, the output is the canonical quiet NaN, whatever the operand payloads are.
- R3: Otherwise, if any enabled operand is a signalling NaN (a NaN whose quiet bit is zero; the quiet bit is bit 22 in single and bit 51 in double), the first such operand in the order operand 1, 2, 3 is returned with its quiet bit set to one.
- R4: Otherwise the first enabled quiet-NaN operand, in the same order, is returned bit-exact.
- R5: `invalid_op` is high exactly when the raw result is a NaN and at least one enabled operand is a signalling NaN.
- R6: With flush-to-zero on, a subnormal raw result (exponent field zero, fraction non-zero) is replaced by a zero that keeps only its sign bit.
- R7: Any other raw result passes through bit-exact, including subnormals when flush-to-zero is off, and `invalid_op` stays low for it.
- R8: In single precision (`sp_mode`=1) only bits 31:0 of every input are used. Bits 63:32 of the inputs are ignored, and bits 63:32 of the output are zero.
- R9: An operand whose enable bit is low takes no part in NaN selection or in `invalid_op`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sp_mode | input | 1 | 1 = single precision in bits 31:0, 0 = double precision |
| ftz_en | input | 1 | Flush subnormal results to signed zero |
| dn_en | input | 1 | Default-NaN mode |
| src_en | input | NUM_OPS | Operand present mask, bit 0 = operand 1 |
| src_ops | input | NUM_OPS x 64 | Operand bit patterns, index 0 = operand 1 |
| raw_res | input | 64 | Raw result from the arithmetic datapath |
| fixed_res | output | 64 | Corrected result |
| invalid_op | output | 1 | Invalid-operation indication |

## Verification
The bench targets the operand priority. It mixes signalling and quiet NaNs in every position, so a design that ranked quiet over signalling NaNs, or scanned the operands in the wrong order, returns the wrong payload. It places signalling NaNs in disabled operand slots and puts garbage in the upper half during single-precision runs; a design that failed to mask either would raise `invalid_op` falsely or misclassify values. Subnormals of both signs, the smallest normal value and zeros probe flush-to-zero: a wrong exponent test would flush normals or lose the sign bit.

// File: rtl/fpfix_pkg.sv
package fpfix_pkg;
  localparam int DW = 64;

  function automatic logic [DW-1:0] canon_qnan(input logic sp);
    return sp ? 64'h0000_0000_7FC0_0000 : 64'h7FF8_0000_0000_0000;
  endfunction

  function automatic logic is_nan(input logic [DW-1:0] v, input logic sp);
    if (sp) return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic logic is_snan(input logic [DW-1:0] v, input logic sp);
    return is_nan(v, sp) && ((v & canon_qnan(sp)) != canon_qnan(sp));
  endfunction

  function automatic logic is_subnormal(input logic [DW-1:0] v, input logic sp);
    if (sp) return (v[30:23] == 8'h00) && (v[22:0] != 23'd0);
    return (v[62:52] == 11'h000) && (v[51:0] != 52'd0);
  endfunction

  function automatic logic [DW-1:0] signed_zero(input logic [DW-1:0] v, input logic sp);
    if (sp) return {32'd0, v[31], 31'd0};
    return {v[63], 63'd0};
  endfunction

  function automatic logic [DW-1:0] quieten(input logic [DW-1:0] v, input logic sp);
    return v | canon_qnan(sp);
  endfunction
endpackage

// File: rtl/fpfix_classify.sv
module fpfix_classify
  import fpfix_pkg::*;
(
  input  logic          sp,
  input  logic          en,
  input  logic [DW-1:0] val,
  output logic          nan,
  output logic          snan
);
  always_comb begin
    nan  = en && is_nan(val, sp);
    snan = en && is_snan(val, sp);
  end
endmodule

// File: rtl/fpfix_nan_pick.sv
module fpfix_nan_pick
  import fpfix_pkg::*;
#(
  parameter int NUM_OPS = 3
) (
  input  logic                        sp,
  input  logic                        dn,
  input  logic [NUM_OPS-1:0][DW-1:0]  ops,
  input  logic [NUM_OPS-1:0]          nan_v,
  input  logic [NUM_OPS-1:0]          snan_v,
  output logic [DW-1:0]               nan_out,
  output logic                        any_snan
);
  logic [DW-1:0] first_s, first_q;
  logic          got_s, got_q;

  always_comb begin
    first_s = '0;
    first_q = '0;
    got_s   = 1'b0;
    got_q   = 1'b0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (snan_v[i] && !got_s) begin
        first_s = quieten(ops[i], sp);
        got_s   = 1'b1;
      end
      if (nan_v[i] && !snan_v[i] && !got_q) begin
        first_q = ops[i];
        got_q   = 1'b1;
      end
    end
    any_snan = got_s;
    if (dn || (!got_s && !got_q)) nan_out = canon_qnan(sp);
    else if (got_s)               nan_out = first_s;
    else                          nan_out = first_q;
  end
endmodule

// File: rtl/fpfix_flush.sv
module fpfix_flush
  import fpfix_pkg::*;
(
  input  logic          sp,
  input  logic          ftz,
  input  logic [DW-1:0] val,
  output logic [DW-1:0] val_out,
  output logic          hit
);
  always_comb begin
    hit     = ftz && is_subnormal(val, sp);
    val_out = hit ? signed_zero(val, sp) : val;
  end
endmodule

// File: rtl/fpfix_top.sv
module fpfix_top
  import fpfix_pkg::*;
#(
  parameter int NUM_OPS = 3
) (
  input  logic                        sp_mode,
  input  logic                        ftz_en,
  input  logic                        dn_en,
  input  logic [NUM_OPS-1:0]          src_en,
  input  logic [NUM_OPS-1:0][DW-1:0]  src_ops,
  input  logic [DW-1:0]               raw_res,
  output logic [DW-1:0]               fixed_res,
  output logic                        invalid_op
);
  localparam int HALF = DW / 2;

  logic [DW-1:0]               keep_mask;
  logic [NUM_OPS-1:0][DW-1:0]  ops_m;
  logic [DW-1:0]               res_m;
  logic [NUM_OPS-1:0]          op_nan, op_snan;
  logic                        res_is_nan;
  logic [DW-1:0]               nan_val, flush_val;
  logic                        snan_seen, flush_hit, pass_through;

  assign keep_mask = sp_mode ? {{HALF{1'b0}}, {HALF{1'b1}}} : {DW{1'b1}};
  assign res_m     = raw_res & keep_mask;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    assign ops_m[g] = src_ops[g] & keep_mask;
    fpfix_classify u_cls (
      .sp   (sp_mode),
      .en   (src_en[g]),
      .val  (ops_m[g]),
      .nan  (op_nan[g]),
      .snan (op_snan[g])
    );
  end

  assign res_is_nan = is_nan(res_m, sp_mode);

  fpfix_nan_pick #(.NUM_OPS(NUM_OPS)) u_pick (
    .sp       (sp_mode),
    .dn       (dn_en),
    .ops      (ops_m),
    .nan_v    (op_nan),
    .snan_v   (op_snan),
    .nan_out  (nan_val),
    .any_snan (snan_seen)
  );

  fpfix_flush u_flush (
    .sp      (sp_mode),
    .ftz     (ftz_en),
    .val     (res_m),
    .val_out (flush_val),
    .hit     (flush_hit)
  );

  assign pass_through = !res_is_nan && !flush_hit;
  assign fixed_res    = res_is_nan ? nan_val : flush_val;
  assign invalid_op   = res_is_nan && snan_seen;
endmodule

// File: rtl/fpfix_checker.sv
module fpfix_checker
  import fpfix_pkg::*;
(
  input logic          sp_mode,
  input logic          dn_en,
  input logic [DW-1:0] raw_res,
  input logic [DW-1:0] fixed_res,
  input logic          invalid_op,
  input logic          res_is_nan,
  input logic          flush_hit,
  input logic          pass_through
);
  always_comb begin
    if (!$isunknown({sp_mode, dn_en, raw_res, fixed_res, invalid_op,
                     res_is_nan, flush_hit, pass_through})) begin
      p_nan_out_r3: assert (!res_is_nan || is_nan(fixed_res, sp_mode))
        else $error("NaN result lost its NaN class");
      p_dn_canon_r2: assert (!(res_is_nan && dn_en) || fixed_res == canon_qnan(sp_mode))
        else $error("default-NaN mode not canonical");
      p_inv_only_nan_r5: assert (!invalid_op || res_is_nan)
        else $error("invalid raised on non-NaN result");
      p_flush_zero_r6: assert (!flush_hit || (fixed_res & ~signed_zero({DW{1'b1}}, sp_mode)) == '0)
        else $error("flushed value not zero");
      p_pass_exact_r7: assert (!pass_through || fixed_res == (sp_mode ? {32'd0, raw_res[31:0]} : raw_res))
        else $error("pass-through altered value");
      p_upper_zero_r8: assert (!sp_mode || fixed_res[63:32] == 32'd0)
        else $error("single mode upper half not zero");
      p_one_path_r7: assert ($countones({res_is_nan, flush_hit, pass_through}) == 1)
        else $error("result path not unique");
    end
  end
endmodule

bind fpfix_top fpfix_checker u_chk (
  .sp_mode      (sp_mode),
  .dn_en        (dn_en),
  .raw_res      (raw_res),
  .fixed_res    (fixed_res),
  .invalid_op   (invalid_op),
  .res_is_nan   (res_is_nan),
  .flush_hit    (flush_hit),
  .pass_through (pass_through)
);

// File: tb/fpfix_top_test.sv
module fpfix_top_test;
  localparam int N = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               sp_mode, ftz_en, dn_en;
  logic [N-1:0]       src_en;
  logic [N-1:0][63:0] src_ops;
  logic [63:0]        raw_res, fixed_res;
  logic               invalid_op;

  int checks = 0;
  int fails  = 0;

  fpfix_top #(.NUM_OPS(N)) uut (
    .sp_mode(sp_mode), .ftz_en(ftz_en), .dn_en(dn_en), .src_en(src_en),
    .src_ops(src_ops), .raw_res(raw_res), .fixed_res(fixed_res),
    .invalid_op(invalid_op)
  );

  // reference helpers written with shifts on field widths
  function automatic int mbits(input logic sp); return sp ? 23 : 52; endfunction
  function automatic int ebits(input logic sp); return sp ? 8 : 11; endfunction
  function automatic logic [63:0] trim(input logic [63:0] v, input logic sp);
    return sp ? (v & 64'hFFFF_FFFF) : v;
  endfunction
  function automatic logic [63:0] expf(input logic [63:0] v, input logic sp);
    return (v >> mbits(sp)) & ((64'd1 << ebits(sp)) - 1);
  endfunction
  function automatic logic [63:0] frac(input logic [63:0] v, input logic sp);
    return v & ((64'd1 << mbits(sp)) - 1);
  endfunction
  function automatic logic m_nan(input logic [63:0] v, input logic sp);
    return expf(v, sp) == ((64'd1 << ebits(sp)) - 1) && frac(v, sp) != 0;
  endfunction
  function automatic logic m_quietbit(input logic [63:0] v, input logic sp);
    return v[mbits(sp) - 1];
  endfunction
  function automatic logic [63:0] m_canon(input logic sp);
    return (((64'd1 << ebits(sp)) - 1) << mbits(sp)) | (64'd1 << (mbits(sp) - 1));
  endfunction

  // returns {tag index, invalid, value}
  function automatic logic [68:0] model(input logic sp, input logic ftz, input logic dn,
                                        input logic [N-1:0] en,
                                        input logic [N-1:0][63:0] ops,
                                        input logic [63:0] res);
    logic [63:0] r, o;
    logic s_any, q_any;
    logic [63:0] s_val, q_val;
    int w;
    r = trim(res, sp);
    w = sp ? 32 : 64;
    s_any = 0; q_any = 0; s_val = 0; q_val = 0;
    for (int i = 0; i < N; i++) begin
      o = trim(ops[i], sp);
      if (en[i] && m_nan(o, sp)) begin
        if (!m_quietbit(o, sp)) begin
          if (!s_any) s_val = o | (64'd1 << (mbits(sp) - 1));
          s_any = 1;
        end else begin
          if (!q_any) q_val = o;
          q_any = 1;
        end
      end
    end
    if (m_nan(r, sp)) begin
      if (dn)          return {4'd2, s_any, m_canon(sp)};
      if (s_any)       return {4'd3, 1'b1, s_val};
      if (q_any)       return {4'd4, 1'b0, q_val};
      return {4'd1, 1'b0, m_canon(sp)};
    end
    if (ftz && expf(r, sp) == 0 && frac(r, sp) != 0)
      return {4'd6, 1'b0, (r >> (w - 1)) << (w - 1)};
    return {4'd7, 1'b0, r};
  endfunction

  function automatic string tag(input int k);
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      6: return "R6";
      8: return "R8";
      9: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string rq);
    logic [68:0] e;
    e = model(sp_mode, ftz_en, dn_en, src_en, src_ops, raw_res);
    checks++;
    if (fixed_res !== e[63:0]) begin
      fails++;
      $display("FAIL %s value: actual %h expected %h", rq == "" ? tag(int'(e[68:65])) : rq,
               fixed_res, e[63:0]);
    end
    checks++;
    if (invalid_op !== e[64]) begin
      fails++;
      $display("FAIL R5 invalid: actual %b expected %b", invalid_op, e[64]);
    end
  endtask

  task automatic apply(input logic sp, input logic ftz, input logic dn, input logic [N-1:0] en,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                       input logic [63:0] r, input string rq);
    @(posedge clk);
    sp_mode = sp; ftz_en = ftz; dn_en = dn; src_en = en;
    src_ops[0] = a; src_ops[1] = b; src_ops[2] = c; raw_res = r;
    @(negedge clk);
    check(rq);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // build a value of a chosen class
  function automatic logic [63:0] gen(input logic sp, input int kind);
    logic [63:0] v, junk;
    int m;
    m = mbits(sp);
    junk = sp ? {$urandom(), 32'd0} : 64'd0;
    v = rnd64() & ((64'd1 << (sp ? 31 : 63)) - 1);
    v = v | ({63'd0, $urandom_range(1)} << (sp ? 31 : 63));
    case (kind)
      0: v = v & ~(((64'd1 << ebits(sp)) - 1) << m);                       // subnormal/zero
      1: v = v | (((64'd1 << ebits(sp)) - 1) << m) | (64'd1 << (m - 1));  // qNaN
      2: begin                                                             // sNaN
           v = (v | (((64'd1 << ebits(sp)) - 1) << m)) & ~(64'd1 << (m - 1));
           if (frac(v, sp) == 0) v = v | 64'd1;
         end
      3: v = (v & ~((64'd1 << m) - 1)) | (((64'd1 << ebits(sp)) - 1) << m); // inf
      default: ;
    endcase
    return trim(v, sp) | junk;
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    sp_mode = 0; ftz_en = 0; dn_en = 0; src_en = '0; src_ops = '0; raw_res = '0;
    void'($urandom(32'd1234));

    // idle inputs: zero passes through, no invalid
    apply(0, 0, 0, 3'b000, 0, 0, 0, 64'h0, "R7");
    // R1 canonical, both precisions
    apply(1, 0, 0, 3'b111, 32'h3F80_0000, 32'h4000_0000, 0, 32'h7FC1_2345, "R1");
    apply(0, 0, 0, 3'b011, 64'h3FF0_0000_0000_0000, 0, 0, 64'hFFF0_0000_0000_0001, "R1");
    // R2 default-NaN overrides sNaN payload, invalid still high
    apply(1, 0, 1, 3'b111, 32'h7F80_0001, 32'h7FC0_0005, 0, 32'h7FC0_0000, "R2");
    // R3 operand 2 sNaN wins over operand 1 qNaN
    apply(1, 0, 0, 3'b111, 32'hFFC0_0042, 32'h7F80_0077, 32'h7F80_0099, 32'h7FC0_0000, "R3");
    apply(0, 0, 0, 3'b111, 64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0002,
          64'hFFF0_0000_0000_0003, 64'h7FF8_0000_0000_0000, "R3");
    // R4 first quiet NaN unchanged
    apply(1, 0, 0, 3'b111, 32'h4040_0000, 32'hFFC0_1234, 32'h7FC0_5678, 32'h7FC0_0000, "R4");
    // R6 flush keeps sign; smallest normal untouched
    apply(1, 1, 0, 3'b000, 0, 0, 0, 32'h8000_0001, "R6");
    apply(0, 1, 0, 3'b000, 0, 0, 0, 64'h000F_FFFF_FFFF_FFFF, "R6");
    apply(1, 1, 0, 3'b000, 0, 0, 0, 32'h0080_0000, "R7");
    apply(1, 0, 0, 3'b000, 0, 0, 0, 32'h8000_0001, "R7");
    // R8 junk in upper half ignored in single mode
    apply(1, 0, 0, 3'b001, 64'hDEAD_BEEF_7F80_0003, 0, 0, 64'h1234_5678_7FC0_0000, "R8");
    apply(1, 1, 0, 3'b000, 0, 0, 0, 64'hFFFF_FFFF_0000_0001, "R8");
    // R9 disabled sNaN ignored
    apply(1, 0, 0, 3'b010, 32'h7F80_0001, 32'h7FC0_0009, 32'h7F80_0002, 32'h7FC0_0000, "R9");
    apply(0, 0, 0, 3'b000, 64'h7FF0_0000_0000_0001, 0, 0, 64'h7FF8_0000_0000_0000, "R9");

    // constrained random mix
    for (int it = 0; it < 4000; it++) begin
      logic sp;
      logic [63:0] a, b, c, r;
      sp = $urandom_range(1);
      a = gen(sp, $urandom_range(5));
      b = gen(sp, $urandom_range(5));
      c = gen(sp, $urandom_range(5));
      r = gen(sp, $urandom_range(4));
      apply(sp, $urandom_range(1), ($urandom_range(3) == 0), 3'($urandom_range(7)),
            a, b, c, r, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule